// File: doc/BRIEF.md
# Data-Ready Triggered ADC Frame Reader

This block is an SPI master that pulls one complete conversion frame out of an eight-channel delta-sigma converter each time the converter reports fresh results. The active-low data-ready line is brought into the system clock domain, and only its high-to-low transition can start a read. After that edge the reader waits a programmable guard interval. It then lowers chip select and sends the single-shot read opcode 0x12. It then clocks in a 24-bit status word followed by eight 24-bit channel results. At the end it raises chip select again, so the converter's serial port is reset on every frame.

The captured words appear on parallel outputs together with a one-cycle strobe, and they hold their values until the next frame completes. A data-ready edge that arrives while a frame is still in progress does not restart the read. It sets a sticky overrun flag instead. The SCLK rate comes from a half-period divider parameter and the guard interval from a cycle-count parameter. With the defaults and a 250 MHz system clock, SCLK runs near 7.8 MHz and a full frame of about 29 µs fits inside one 62.5 µs conversion period at 16 kSPS.

Top module: `adc_frame_reader`

## Requirements
- R1: SPI mode 1 timing: SCLK idles low, MOSI changes only at a rising SCLK edge and stays stable while SCLK is high, and MISO is sampled at each falling SCLK edge.
- R2: Each frame, bounded by one low period of cs_n, has exactly 224 SCLK rising edges.
- R3: The first 8 bits on MOSI are the opcode 0x12, most significant bit first. MOSI is low for the remaining 216 bits of the frame.
- R4: The 24 MISO bits after the opcode are the status word, most significant bit first. The next eight 24-bit groups are channels 0 to 7 in that order, with channel k placed on ch_data[24k+23:24k].
- R5: cs_n is high while idle and low for the entire frame. At least HALF_DIV system cycles separate the fall of cs_n from the first SCLK rise, and the same minimum separates the last SCLK fall from the rise of cs_n.
- R6: A frame starts only after a high-to-low transition of drdy_n. A rising edge, or a level that stays low, starts nothing.
- R7: cs_n stays high for at least GUARD_CYC system cycles after the drdy_n falling edge, so the opcode is never shifted right next to a data update.
- R8: frame_valid is a one-cycle pulse in the same cycle that cs_n returns high. status_word and ch_data hold their values until the next frame completes.
- R9: A drdy_n falling edge while a read is pending or in progress sets overrun, which stays set until reset. The running frame completes once and is not restarted.
- R10: While en is low, drdy_n falling edges are ignored: no frame starts and overrun is not set. A frame already under way completes even if en drops.
- R11: After reset, cs_n=1, sclk=0, mosi=0, frame_valid=0, overrun=0, and status_word and ch_data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Allows data-ready edges to start frames |
| drdy_n | input | 1 | Asynchronous active-low data-ready from the converter |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the converter |
| cs_n | output | 1 | Active-low chip select |
| status_word | output | 24 | Status word from the last frame |
| ch_data | output | 192 | Eight channel results from the last frame, channel 0 in the low bits |
| frame_valid | output | 1 | One-cycle strobe when a new frame is available |
| overrun | output | 1 | Sticky flag for a data-ready edge during a frame |

## Verification
The bench goes after word alignment first. A reader that loses or gains one SCLK, or that starts its shift register at the opcode instead of after it, would shift every channel by a bit, and the all-ones and alternating patterns expose that at once. It checks that MOSI falls to zero after the opcode, which a design replaying the opcode or leaving the last opcode bit on the line would break. It also measures the guard gap between the data-ready edge and chip select, and the setup and hold margins around SCLK, since a missing guard would let the command collide with a data update. Finally it fires a second data-ready edge in the middle of a frame, and pulses data-ready while disabled, to catch a reader that restarts, aborts, or raises a false overrun.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  parameter int WORD_W     = 24;
  parameter int NCH        = 8;
  parameter int OP_W       = 8;
  parameter logic [OP_W-1:0] RD_OPCODE = 8'h12;
  parameter int DATA_BITS  = (NCH + 1) * WORD_W;
  parameter int FRAME_BITS = OP_W + DATA_BITS;
  parameter int BIDX_W     = $clog2(FRAME_BITS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GUARD,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD
  } rd_state_t;
endpackage

// File: rtl/adc_rd_drdy_edge.sv
module adc_rd_drdy_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic drdy_n,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], drdy_n};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall = last_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int HALF_DIV  = 16,
  parameter int GUARD_CYC = 750
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic fall,
  output logic sclk,
  output logic mosi,
  output logic cs_n,
  output logic smp,
  output logic fin,
  output logic overrun
);
  localparam int CMAX  = (GUARD_CYC > HALF_DIV) ? GUARD_CYC : HALF_DIV;
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam logic [CNT_W-1:0] HALF_LAST  = CNT_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] GUARD_LAST = CNT_W'(GUARD_CYC - 1);
  localparam logic [BIDX_W-1:0] BIT_LAST  = BIDX_W'(FRAME_BITS - 1);

  rd_state_t         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIDX_W-1:0] bidx_q;
  logic [OP_W-1:0]   op_q;
  logic              half_done;

  assign half_done = (cnt_q == HALF_LAST);
  assign smp = (st_q == ST_SHIFT) && half_done && sclk;
  assign fin = (st_q == ST_HOLD) && half_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      op_q    <= '0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      cs_n    <= 1'b1;
      overrun <= 1'b0;
    end else begin
      if (fall && en && st_q != ST_IDLE) overrun <= 1'b1;
      case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (fall && en) st_q <= ST_GUARD;
        end
        ST_GUARD: begin
          if (cnt_q == GUARD_LAST) begin
            cnt_q <= '0;
            cs_n  <= 1'b0;
            st_q  <= ST_SETUP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SETUP: begin
          if (half_done) begin
            cnt_q  <= '0;
            sclk   <= 1'b1;
            mosi   <= RD_OPCODE[OP_W-1];
            op_q   <= RD_OPCODE << 1;
            bidx_q <= '0;
            st_q   <= ST_SHIFT;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (half_done) begin
            cnt_q <= '0;
            if (sclk) begin
              sclk <= 1'b0;
              if (bidx_q == BIT_LAST) st_q <= ST_HOLD;
              else                    bidx_q <= bidx_q + 1'b1;
            end else begin
              sclk <= 1'b1;
              mosi <= op_q[OP_W-1];
              op_q <= op_q << 1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (half_done) begin
            cnt_q <= '0;
            cs_n  <= 1'b1;
            mosi  <= 1'b0;
            st_q  <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture
  import adc_rd_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp,
  input  logic                    miso,
  input  logic                    fin,
  output logic [WORD_W-1:0]       status_word,
  output logic [NCH*WORD_W-1:0]   ch_data,
  output logic                    frame_valid
);
  logic [DATA_BITS-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q        <= '0;
      status_word <= '0;
      ch_data     <= '0;
      frame_valid <= 1'b0;
    end else begin
      frame_valid <= fin;
      if (smp) sh_q <= {sh_q[DATA_BITS-2:0], miso};
      if (fin) begin
        status_word <= sh_q[DATA_BITS-1 -: WORD_W];
        for (int i = 0; i < NCH; i++)
          ch_data[i*WORD_W +: WORD_W] <= sh_q[(NCH-1-i)*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adc_rd_pkg::*;
#(
  parameter int HALF_DIV    = 16,
  parameter int GUARD_CYC   = 750,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic                  drdy_n,
  input  logic                  miso,
  output logic                  sclk,
  output logic                  mosi,
  output logic                  cs_n,
  output logic [WORD_W-1:0]     status_word,
  output logic [NCH*WORD_W-1:0] ch_data,
  output logic                  frame_valid,
  output logic                  overrun
);
  logic fall, smp, fin;

  adc_rd_drdy_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
    .clk(clk), .rst(rst), .drdy_n(drdy_n), .fall(fall)
  );

  adc_rd_seq #(.HALF_DIV(HALF_DIV), .GUARD_CYC(GUARD_CYC)) i_seq (
    .clk(clk), .rst(rst), .en(en), .fall(fall),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .smp(smp), .fin(fin), .overrun(overrun)
  );

  adc_rd_capture i_cap (
    .clk(clk), .rst(rst), .smp(smp), .miso(miso), .fin(fin),
    .status_word(status_word), .ch_data(ch_data), .frame_valid(frame_valid)
  );
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk (
  input logic clk,
  input logic rst,
  input logic sclk,
  input logic mosi,
  input logic cs_n,
  input logic frame_valid,
  input logic overrun
);
  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  p_cs_setup_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |=> !sclk);

  p_mosi_stable_r1: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid);

  p_valid_cs_r8: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> (cs_n && !$past(cs_n)));

  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
endmodule

bind adc_frame_reader adc_frame_reader_chk i_chk (
  .clk(clk), .rst(rst), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
  .frame_valid(frame_valid), .overrun(overrun)
);

// File: tb/test_adc_frame_reader.sv
module test_adc_frame_reader;
  localparam int HALF  = 16;
  localparam int GUARD = 750;
  localparam int WD    = 190000;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, drdy_n = 1'b1, miso = 1'b0;
  logic sclk, mosi, cs_n, frame_valid, overrun;
  logic [23:0]  status_word;
  logic [191:0] ch_data;

  always #2 clk = ~clk;

  adc_frame_reader #(.HALF_DIV(HALF), .GUARD_CYC(GUARD)) i_adc_frame_reader (
    .clk(clk), .rst(rst), .en(en), .drdy_n(drdy_n), .miso(miso),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .status_word(status_word),
    .ch_data(ch_data), .frame_valid(frame_valid), .overrun(overrun)
  );

  int nchk = 0, nerr = 0;
  bit fin_run = 0;

  // converter model: launches on rising SCLK, records MOSI on falling SCLK
  logic [223:0] tx = '0;
  logic [223:0] rx = '0;
  int txcnt = 0, rises = 0;
  always @(posedge sclk or posedge cs_n) begin
    if (cs_n) txcnt <= 0;
    else begin
      miso  <= tx[223 - txcnt];
      txcnt <= txcnt + 1;
      rises <= rises + 1;
    end
  end
  always @(negedge sclk) if (!cs_n) rx <= {rx[222:0], mosi};

  // timing monitor
  int cyc = 0, t_csf = 0, t_r1 = 0, t_lf = 0, t_csr = 0, vcount = 0, vbad = 0;
  bit first_r = 0, p_cs = 1, p_sclk = 0;
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (p_cs && !cs_n) begin t_csf = cyc; first_r = 1; end
      if (!p_sclk && sclk && first_r) begin t_r1 = cyc; first_r = 0; end
      if (p_sclk && !sclk) t_lf = cyc;
      if (!p_cs && cs_n) t_csr = cyc;
      if (frame_valid) begin
        vcount++;
        if (!(cs_n && !p_cs)) vbad++;
      end
    end
    p_cs = cs_n;
    p_sclk = sclk;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] chval(input logic [23:0] seed, input int i);
    case (seed)
      24'hFFFFFF: chval = 24'hFFFFFF;
      24'h000000: chval = (i % 2 == 0) ? 24'hAAAAAA : 24'h555555;
      default:    chval = seed ^ (24'h0F1E2D * 24'(i + 1)) ^ 24'(i << 20);
    endcase
  endfunction

  task automatic load_tx(input logic [23:0] st, input logic [23:0] seed);
    tx = '0;
    tx[215:192] = st;
    for (int i = 0; i < 8; i++) tx[191 - 24*i -: 24] = chval(seed, i);
  endtask

  int t_dr = 0;
  task automatic pulse_drdy();
    @(negedge clk);
    drdy_n = 1'b0;
    t_dr = cyc;
    repeat (20) @(negedge clk);
    drdy_n = 1'b1;
  endtask

  task automatic wait_valid(input int v0);
    int n = 0;
    while (vcount == v0 && n < 20000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic check_frame(input logic [23:0] st, input logic [23:0] seed, input int v0, input int r0);
    chk(vcount == v0 + 1, "R8 one valid per frame", 64'(vcount - v0), 64'(1));
    chk(status_word == st, "R4 status word", 64'(status_word), 64'(st));
    for (int i = 0; i < 8; i++)
      chk(ch_data[24*i +: 24] == chval(seed, i), "R4 channel", 64'(ch_data[24*i +: 24]), 64'(chval(seed, i)));
    chk(rx[223:216] == 8'h12, "R3 opcode", 64'(rx[223:216]), 64'h12);
    chk(rx[215:0] == '0, "R3 MOSI low after opcode", 64'(rx[63:0]), 64'(0));
    chk(rises - r0 == 224, "R2 SCLK count", 64'(rises - r0), 64'(224));
    chk(t_csf - t_dr >= GUARD, "R7 guard gap", 64'(t_csf - t_dr), 64'(GUARD));
    chk(t_r1 - t_csf >= HALF, "R5 CS setup", 64'(t_r1 - t_csf), 64'(HALF));
    chk(t_csr - t_lf >= HALF, "R5 CS hold", 64'(t_csr - t_lf), 64'(HALF));
    chk(cs_n && !sclk, "R1 idle bus after frame", {62'(0), cs_n, sclk}, 64'h2);
    chk(vbad == 0, "R8 valid with cs_n rise", 64'(vbad), 64'(0));
  endtask

  localparam logic [47:0] VEC [4] = '{
    {24'h800001, 24'h123456},
    {24'hFFFFFF, 24'hFFFFFF},
    {24'hC00000, 24'h000000},
    {24'h0A5F3C, 24'h7E0081}
  };

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!fin_run) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=<%0d cycles", WD, WD);
      summary();
      $finish;
    end
  end

  initial begin
    int v0, r0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(cs_n == 1 && sclk == 0 && mosi == 0, "R11 bus reset", {61'(0), cs_n, sclk, mosi}, 64'h4);
    chk(frame_valid == 0 && overrun == 0, "R11 flags reset", {62'(0), frame_valid, overrun}, 64'(0));
    chk(status_word == 0 && ch_data == 0, "R11 data reset", 64'(status_word), 64'(0));

    // R10: falling edge while disabled is ignored
    v0 = vcount;
    @(negedge clk); drdy_n = 1'b0;
    repeat (GUARD + 600) @(negedge clk);
    chk(vcount == v0 && cs_n, "R10 disabled edge ignored", 64'(vcount - v0), 64'(0));
    chk(!overrun, "R10 no overrun while disabled", 64'(overrun), 64'(0));
    // R6: enable with drdy already low, then a rising edge only
    en = 1'b1;
    repeat (200) @(negedge clk);
    drdy_n = 1'b1;
    repeat (GUARD + 600) @(negedge clk);
    chk(vcount == v0 && cs_n, "R6 no start on level or rising edge", 64'(vcount - v0), 64'(0));

    // table-driven frames
    for (int k = 0; k < 4; k++) begin
      load_tx(VEC[k][47:24], VEC[k][23:0]);
      v0 = vcount; r0 = rises;
      pulse_drdy();
      wait_valid(v0);
      check_frame(VEC[k][47:24], VEC[k][23:0], v0, r0);
    end
    chk(!overrun, "R9 no overrun on spaced frames", 64'(overrun), 64'(0));

    // R8: outputs hold after the strobe
    repeat (300) @(negedge clk);
    chk(status_word == VEC[3][47:24], "R8 status held", 64'(status_word), 64'(VEC[3][47:24]));

    // R9: second edge mid-frame -> overrun, single frame
    load_tx(24'h3C3C3C, 24'h55AA55);
    v0 = vcount; r0 = rises;
    pulse_drdy();
    repeat (GUARD + 1500) @(negedge clk);
    chk(!cs_n, "R9 frame running at second edge", 64'(cs_n), 64'(0));
    @(negedge clk); drdy_n = 1'b0;
    repeat (20) @(negedge clk); drdy_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(overrun, "R9 overrun set", 64'(overrun), 64'(1));
    wait_valid(v0);
    check_frame(24'h3C3C3C, 24'h55AA55, v0, r0);
    repeat (GUARD + 200) @(negedge clk);
    chk(vcount == v0 + 1 && cs_n, "R9 no restart", 64'(vcount - v0), 64'(1));

    // R10: enable dropped mid-frame, frame completes; overrun stays (R9)
    load_tx(24'h00FF00, 24'h2468AC);
    v0 = vcount; r0 = rises;
    pulse_drdy();
    repeat (GUARD + 400) @(negedge clk);
    en = 1'b0;
    wait_valid(v0);
    check_frame(24'h00FF00, 24'h2468AC, v0, r0);
    chk(overrun, "R9 overrun sticky", 64'(overrun), 64'(1));

    fin_run = 1;
    summary();
    $finish;
  end
endmodule